// File: doc/BRIEF.md
# Compare Timer with Pulse and Toggle Output

The block is a 24-bit up-counting timer. Software writes a start value, a match value and a control word through a simple register port. When the timer is armed, the counter is cleared. On the first tick it takes the start value, and on each later tick it counts up by one. Ticks come either from a strobe the block makes on every second system clock or from an external prescaler strobe.

When the count reaches the match value, a sticky match flag is set. The single output pin then reacts in one of two ways. In pulse mode it leaves its idle level for exactly one tick. In toggle mode it flips on every match. An auto-reload bit decides what follows a match: either the next tick reloads the start value, or the counter keeps counting up. When the counter wraps from all ones to zero, a sticky wrap flag is set. Each flag drives a level interrupt request through its own enable bit. The live count can be read at any time.

Register map. Addresses are 3 bits:
- 0 is the control word.
- 1 is the status word.
- 2 is the start value.
- 3 is the match value.
- 4 is the count, which is read-only.

Control bits:
- [0] arm
- [4:1] mode
- [5] idle polarity
- [6] auto-reload
- [7] tick source (0 = every second clock, 1 = prescaler strobe)
- [8] match interrupt enable
- [9] wrap interrupt enable

Status bits: [0] is the match flag and [1] is the wrap flag.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count, the output pin, both flags, both interrupt requests and all registers read as zero.
- R2: Writing the control word with bit 0 set while the timer is not armed clears the count to zero. In the same write, the output pin takes the value of control bit 5.
- R3: On the first tick after arming, the count takes the start value (address 2). On every later tick it increases by one, unless R8 applies.
- R4: With control bit 7 at 0, a tick occurs on every second system clock, from a divider that runs freely from reset. With bit 7 at 1, a tick occurs only in cycles where the input presc_tick is high.
- R5: A tick that makes the count equal to the match value (address 3) sets status bit 0. irq_cmp is high exactly while that flag and control bit 8 are both set.
- R6: In pulse mode (control bits [4:1] = 4'b0001), a matching tick drives the pin to the inverse of control bit 5. The next tick returns the pin to the value of control bit 5.
- R7: In toggle mode (bits [4:1] = 4'b0010), each matching tick inverts the pin. In any other mode value, the pin holds its level.
- R8: With control bit 6 set, the tick after a matching tick loads the start value. With bit 6 clear, the count keeps incrementing past the match.
- R9: A tick that increments the count from 24'hFFFFFF gives zero and sets status bit 1. irq_ovf is high exactly while that flag and control bit 9 are both set.
- R10: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. A flag set in the same cycle as a clear stays set.
- R11: While the timer is not armed, the count and the output pin hold their values and no flag is set.
- R12: rd_data returns the register selected by rd_addr in the same cycle, and reading has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 24 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 24 | Read data, combinational from rd_addr |
| presc_tick | input | 1 | External single-cycle tick strobe |
| tmr_out | output | 1 | Timer output pin |
| irq_cmp | output | 1 | Match interrupt request (level) |
| irq_ovf | output | 1 | Wrap interrupt request (level) |

## Verification
The assertions assume the following about the inputs:
- presc_tick is a synchronous strobe that is valid only on clock edges.
- Register writes happen one per cycle through wr_en.
- The arm bit can rise only through a write to address 0.

The bench drives every input on the falling clock edge, so each is stable across a rising edge. It pulses presc_tick for one cycle at a time. It changes the control word only through single-cycle writes, including the disarm and re-arm sequences that the start and hold properties depend on.

// File: rtl/cmp_timer_pkg.sv
// Package: shared register addresses, the control word layout and mode codes.
// Assumes: the data path is at least CTRL_W bits wide.
package cmp_timer_pkg;
    localparam int ADDR_W = 3;
    localparam int CTRL_W = 10;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_START = 3'd2;
    localparam logic [ADDR_W-1:0] A_MATCH = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

    localparam logic [3:0] MODE_PULSE  = 4'b0001;
    localparam logic [3:0] MODE_TOGGLE = 4'b0010;

    // Control word, most significant field first.
    typedef struct packed {
        logic       ovf_ie;
        logic       cmp_ie;
        logic       src_ext;
        logic       reload;
        logic       pol;
        logic [3:0] mode;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/cmp_timer_tick.sv
// Tick source: selects either a free-running divide-by-two strobe or the
// external prescaler strobe, gated by the arm bit.
// Assumes: presc_tick is synchronous to clk and one cycle wide.
module cmp_timer_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic src_ext,
    input  logic presc_tick,
    output logic tick
);
    logic phase;

    // Alternate phase every clock, so a strobe falls on every second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Tick: the selected strobe, only while the timer is armed.
    always_comb tick = run & (src_ext ? presc_tick : phase);
endmodule

// File: rtl/cmp_timer_regs.sv
// Register file: control, start and match values, sticky flags,
// read mux and interrupt levels.
// Assumes: one write per cycle; a flag set beats a clear in the same cycle.
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [CNT_W-1:0]  count,
    input  logic              cmp_set,
    input  logic              ovf_set,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  start_val,
    output logic [CNT_W-1:0]  match_val,
    output logic              start,
    output logic              start_pol,
    output logic              cmp_flag,
    output logic              ovf_flag,
    output logic              irq_cmp,
    output logic              irq_ovf
);
    localparam int PAD_W = CNT_W - CTRL_W;

    ctrl_t wr_ctrl;
    logic  stat_wr;

    // Decode the incoming write as a control word and find arm and clear strobes.
    always_comb begin
        wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
        start     = wr_en && (wr_addr == A_CTRL) && wr_ctrl.run && !ctrl.run;
        start_pol = wr_ctrl.pol;
        stat_wr   = wr_en && (wr_addr == A_STAT);
    end

    // Hold the software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            start_val <= '0;
            match_val <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL)  ctrl      <= wr_ctrl;
            if (wr_addr == A_START) start_val <= wr_data;
            if (wr_addr == A_MATCH) match_val <= wr_data;
        end
    end

    // Sticky flags: write one to clear, and a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            cmp_flag <= (cmp_flag & ~(stat_wr & wr_data[0])) | cmp_set;
            ovf_flag <= (ovf_flag & ~(stat_wr & wr_data[1])) | ovf_set;
        end
    end

    // Level interrupt requests.
    always_comb begin
        irq_cmp = cmp_flag & ctrl.cmp_ie;
        irq_ovf = ovf_flag & ctrl.ovf_ie;
    end

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{PAD_W{1'b0}}, ctrl};
            A_STAT:  rd_data = {{(CNT_W-2){1'b0}}, ovf_flag, cmp_flag};
            A_START: rd_data = start_val;
            A_MATCH: rd_data = match_val;
            A_COUNT: rd_data = count;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cmp_timer_core.sv
// Counter core: preload on the first tick, increment, reload after a match,
// wrap detection and output pin shaping per mode.
// Assumes: start and tick never coincide, because tick is gated by the arm
// bit, which is still low in the cycle start is raised.
module cmp_timer_core
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_pol,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             first_pend,
    output logic             reld_pend,
    output logic             cmp_set,
    output logic             ovf_set,
    output logic             tmr_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] nxt;
    logic             inc_path;
    logic             hit;

    // Next count for a tick, and the events it raises.
    always_comb begin
        inc_path = !first_pend && !reld_pend;
        nxt      = inc_path ? count + 1'b1 : start_val;
        hit      = (nxt == match_val);
        cmp_set  = tick && hit;
        ovf_set  = tick && inc_path && (count == CNT_MAX);
    end

    // Counter and pending-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            first_pend <= 1'b0;
            reld_pend  <= 1'b0;
        end else if (start) begin
            count      <= '0;
            first_pend <= 1'b1;
            reld_pend  <= 1'b0;
        end else if (tick) begin
            count      <= nxt;
            first_pend <= 1'b0;
            reld_pend  <= hit && ctrl.reload;
        end
    end

    // Output pin: polarity on arm, then shaped per mode on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_out <= 1'b0;
        end else if (start) begin
            tmr_out <= start_pol;
        end else if (tick) begin
            case (ctrl.mode)
                MODE_PULSE:  tmr_out <= hit ? ~ctrl.pol : ctrl.pol;
                MODE_TOGGLE: tmr_out <= hit ? ~tmr_out : tmr_out;
                default:     tmr_out <= tmr_out;
            endcase
        end
    end
endmodule

// File: rtl/cmp_timer.sv
// Top: compare timer with pulse or toggle output and a register port.
// Assumes: one clock domain, synchronous active-low reset.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              presc_tick,
    output logic              tmr_out,
    output logic              irq_cmp,
    output logic              irq_ovf
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] match_val;
    logic [CNT_W-1:0] count;
    logic             start;
    logic             start_pol;
    logic             tick;
    logic             first_pend;
    logic             reld_pend;
    logic             cmp_set;
    logic             ovf_set;
    logic             cmp_flag;
    logic             ovf_flag;
    logic             run_q;
    logic [3:0]       mode_q;

    // Expose control fields as plain nets.
    always_comb begin
        run_q  = ctrl.run;
        mode_q = ctrl.mode;
    end

    cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .cmp_set(cmp_set), .ovf_set(ovf_set),
        .ctrl(ctrl), .start_val(start_val), .match_val(match_val),
        .start(start), .start_pol(start_pol),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    cmp_timer_tick u_tick (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .src_ext(ctrl.src_ext), .presc_tick(presc_tick), .tick(tick)
    );

    cmp_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_pol(start_pol), .tick(tick), .ctrl(ctrl),
        .start_val(start_val), .match_val(match_val),
        .count(count), .first_pend(first_pend), .reld_pend(reld_pend),
        .cmp_set(cmp_set), .ovf_set(ovf_set), .tmr_out(tmr_out)
    );
endmodule

// File: rtl/cmp_timer_chk.sv
// Checker: temporal properties of the compare timer, bound into the top.
// Assumes: inputs change only between rising clock edges.
module cmp_timer_chk
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              run_q,
    input logic              start,
    input logic              tick,
    input logic              first_pend,
    input logic              reld_pend,
    input logic [CNT_W-1:0]  count,
    input logic              tmr_out,
    input logic              cmp_flag,
    input logic              ovf_flag,
    input logic              irq_cmp
);
    // R2: arming clears the count and sets up the preload.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0) && first_pend);

    // R3: a plain tick advances the count by one.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !first_pend && !reld_pend && count != '1)
        |=> count == $past(count) + 1'b1);

    // R5: the match request is never raised without its flag.
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp |-> cmp_flag);

    // R6: the pin changes only on a tick or on arming.
    a_r6_pin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(tmr_out));

    // R9: incrementing from all ones wraps to zero and flags it.
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !first_pend && !reld_pend && count == '1)
        |=> ovf_flag && count == '0);

    // R10: the match flag stays set unless cleared by writing 1.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !(wr_en && wr_addr == A_STAT && wr_data[0])) |=> cmp_flag);

    // R11: a disarmed timer holds its count.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> $stable(count));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run_q(run_q), .start(start), .tick(tick),
    .first_pend(first_pend), .reld_pend(reld_pend), .count(count),
    .tmr_out(tmr_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .irq_cmp(irq_cmp)
);

// File: tb/cmp_timer_test.sv
// Bench: a behavioural reference model is updated on every rising edge and
// compared with the outputs 3 ns later, plus directed checks per requirement.
module cmp_timer_test;
    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [2:0]    rd_addr = 3'd4;
    logic [W-1:0]  rd_data;
    logic          presc_tick = 1'b0;
    logic          tmr_out;
    logic          irq_cmp;
    logic          irq_ovf;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit presc_on = 0;

    cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .presc_tick(presc_tick), .tmr_out(tmr_out),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    always #5 clk = ~clk;

    // Reference model state.
    logic [W-1:0] m_cnt, m_start, m_match;
    logic [9:0]   m_ctrl;
    bit m_ph, m_first, m_rl, m_out, m_cf, m_of;

    always @(posedge clk) begin
        bit tk, arm, hit, wrapped;
        logic [W-1:0] nx;
        if (!rst_n) begin
            m_cnt = '0; m_start = '0; m_match = '0; m_ctrl = '0;
            m_ph = 0; m_first = 0; m_rl = 0; m_out = 0; m_cf = 0; m_of = 0;
        end else begin
            tk  = m_ctrl[0] && (m_ctrl[7] ? presc_tick : m_ph);
            m_ph = !m_ph;
            arm = wr_en && wr_addr == 3'd0 && wr_data[0] && !m_ctrl[0];
            if (wr_en && wr_addr == 3'd1) begin
                if (wr_data[0]) m_cf = 0;
                if (wr_data[1]) m_of = 0;
            end
            if (arm) begin
                m_cnt = '0; m_first = 1; m_rl = 0; m_out = wr_data[5];
            end else if (tk) begin
                wrapped = 0;
                if (m_first || m_rl) nx = m_start;
                else begin
                    wrapped = (m_cnt == 24'hFFFFFF);
                    nx = m_cnt + 24'd1;
                end
                hit = (nx == m_match);
                if (hit) m_cf = 1;
                if (wrapped) m_of = 1;
                if (m_ctrl[4:1] == 4'b0001) m_out = hit ? !m_ctrl[5] : m_ctrl[5];
                else if (m_ctrl[4:1] == 4'b0010 && hit) m_out = !m_out;
                m_cnt = nx; m_first = 0; m_rl = hit && m_ctrl[6];
            end
            if (wr_en) begin
                if (wr_addr == 3'd0) m_ctrl = wr_data[9:0];
                if (wr_addr == 3'd2) m_start = wr_data;
                if (wr_addr == 3'd3) m_match = wr_data;
            end
        end
    end

    task automatic check(input bit ok, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] model_rd();
        case (rd_addr)
            3'd0: return {14'd0, m_ctrl};
            3'd1: return {22'd0, m_of, m_cf};
            3'd2: return m_start;
            3'd3: return m_match;
            3'd4: return m_cnt;
            default: return '0;
        endcase
    endfunction

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check(tmr_out == m_out, "R2/R6/R7 pin", {23'd0, tmr_out}, {23'd0, m_out});
            check(irq_cmp == (m_cf && m_ctrl[8]), "R5 irq_cmp",
                  {23'd0, irq_cmp}, {23'd0, m_cf && m_ctrl[8]});
            check(irq_ovf == (m_of && m_ctrl[9]), "R9 irq_ovf",
                  {23'd0, irq_ovf}, {23'd0, m_of && m_ctrl[9]});
            check(rd_data == model_rd(), "R3/R4/R8/R12 read data", rd_data, model_rd());
        end
    end

    // Prescaler strobe: one cycle high out of every three, when enabled.
    always @(negedge clk) begin
        int k;
        k = (k + 1) % 3;
        presc_tick <= presc_on && (k == 0);
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        bit held_pin;
        idle(3);
        rst_n = 1'b1;
        @(posedge clk); #3;
        // R1: reset state.
        check(rd_data == 0 && tmr_out == 0 && !irq_cmp && !irq_ovf,
              "R1 reset state", rd_data, 0);

        // Pulse mode, two-clock ticks, auto-reload, polarity 0.
        wr(3'd2, 24'd5);
        wr(3'd3, 24'd8);
        wr(3'd0, 24'h143); // cmp_ie, reload, mode 0001, arm
        @(posedge clk); #3;
        // R2: arm clears the count and loads the polarity.
        check(rd_data == 0 && tmr_out == 0, "R2 arm clears count", rd_data, 0);
        idle(60); // R3 R4 R6 R8 covered by the model comparison
        @(posedge clk); #3;
        check(irq_cmp == 1, "R5 match request raised", {23'd0, irq_cmp}, 1);
        // R10: writing 0 keeps the flag; writing 1 clears it.
        wr(3'd1, 24'd0);
        check(irq_cmp == 1, "R10 zero write keeps flag", {23'd0, irq_cmp}, 1);
        wr(3'd0, 24'h142); // disarm
        wr(3'd1, 24'd1);
        @(posedge clk); #3;
        check(irq_cmp == 0, "R10 write one clears flag", {23'd0, irq_cmp}, 0);

        // R11: disarmed timer holds count and pin.
        held = rd_data; held_pin = tmr_out;
        idle(12);
        @(posedge clk); #3;
        check(rd_data == held && tmr_out == held_pin, "R11 hold while disarmed", rd_data, held);

        // Toggle mode, prescaler ticks, polarity 1, free-running, wrap enabled.
        wr(3'd2, 24'hFFFFF0);
        wr(3'd3, 24'hFFFFF4);
        wr(3'd0, 24'h3A5); // ovf_ie, cmp_ie, src_ext, pol, mode 0010, arm
        @(posedge clk); #3;
        check(tmr_out == 1, "R2 arm sets polarity 1", {23'd0, tmr_out}, 1);
        // R4: with no prescaler strobes the count must not move.
        idle(10);
        @(posedge clk); #3;
        check(rd_data == 0, "R4 no strobe no tick", rd_data, 0);
        presc_on = 1;
        idle(90); // R7 toggles, R8 runs past match, R9 wraps
        @(posedge clk); #3;
        check(irq_ovf == 1, "R9 wrap request raised", {23'd0, irq_ovf}, 1);
        // R12: reading other registers while running.
        rd_addr = 3'd2;
        @(posedge clk); #3;
        check(rd_data == 24'hFFFFF0, "R12 start value readback", rd_data, 24'hFFFFF0);
        rd_addr = 3'd4;
        idle(20);
        presc_on = 0;

        // Toggle with auto-reload, two-clock ticks: periodic matches.
        wr(3'd0, 24'd0);
        wr(3'd2, 24'd2);
        wr(3'd3, 24'd4);
        wr(3'd0, 24'h045); // reload, mode 0010, arm
        idle(40); // R7 R8
        @(posedge clk); #3;
        check(rd_data >= 2 && rd_data <= 4, "R8 count stays in reload window", rd_data, 4);
        idle(2);
        finish_run();
    end
endmodule